// File: doc/BRIEF.md
# Cartridge Bank Controller and Address Decoder

This block sits between an 8-bit processor's 16-bit bus and the memories of a handheld-style system. Each cycle it classifies the current address. It raises one device select, forms the physical address that device expects and steers the matching read byte back to the processor. The memories themselves live outside the block. All read lanes arrive packed on one input, and one shared address output and one write strobe drive the selected device.

Stores into the lower half of the map do not reach the cartridge ROM. They program three control values instead: an external-RAM enable, a ROM bank number for the switchable window, and a RAM bank number for the external-RAM window. A small boot image overlays two holes near the bottom of the map until a dedicated clear input turns it off for good. Decoding is combinational. Control writes take effect at the next rising clock edge.

Device lanes (bit of `dev_sel`, byte lane of `dev_rdata`): 0 boot image, 1 cartridge ROM, 2 external RAM, 3 work RAM, 4 display memory, 5 I/O space, 6 high RAM, 7 interrupt-enable register. Lane i occupies `dev_rdata[8i+7:8i]`.

Top module: `cart_bank_map`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, external RAM is disabled and the boot overlay is active.
- R2: A write with address below 0x2000 enables external RAM when the data byte is exactly 0x0A and disables it for any other byte.
- R3: A write in 0x2000..0x3FFF sets the ROM bank to the low 7 data bits. A data byte of 0x00 selects bank 1, while a non-zero byte whose low 7 bits are zero (0x80) selects bank 0.
- R4: A write in 0x4000..0x5FFF sets the RAM bank to the low 2 data bits. Writes in 0x6000..0x7FFF change no control value.
- R5: Reads below 0x4000 select lane 1 with `dev_addr` equal to the address. Reads in 0x4000..0x7FFF select lane 1 with `dev_addr` = bank×0x4000 + (address−0x4000).
- R6: With external RAM enabled, 0xA000..0xBFFF selects lane 2 with `dev_addr` = RAM bank×0x2000 + (address−0xA000). With it disabled, nothing is selected, `rd_data` is 0xFF and `dev_we` stays low.
- R7: While the overlay is active, addresses below 0x0100 and in 0x0200..0x08FF select lane 0 with `dev_addr` equal to the address, and 0x0100..0x01FF still goes to ROM. One cycle of `boot_clr` turns the overlay off until the next reset.
- R8: 0xC000..0xDFFF selects lane 3 with `dev_addr` = address−0xC000, so bit 12 picks the second page. 0x8000..0x9FFF and 0xFE00..0xFE9F select lane 4 with `dev_addr` = address with bit 15 cleared.
- R9: 0xFF00..0xFF7F selects lane 5 and 0xFF80..0xFFFE selects lane 6, each with `dev_addr` = low 7 address bits. 0xFFFF selects lane 7 with `dev_addr` 0.
- R10: Unmapped addresses (0xE000..0xFDFF, 0xFEA0..0xFEFF) select nothing, read 0x00 and never raise `dev_we`.
- R11: At most one select is high, and `rd_data` equals the byte lane of the selected device.
- R12: `dev_we` follows `cpu_we` only for writable targets (enabled external RAM, work RAM, display, I/O, high RAM, interrupt enable). It is never raised for addresses below 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe for the current address |
| boot_clr | input | 1 | Turns the boot overlay off permanently |
| dev_rdata | input | 64 | Packed read bytes, one lane per device |
| dev_sel | output | 8 | One-hot device select |
| dev_addr | output | 21 | Physical address inside the selected device |
| dev_we | output | 1 | Write strobe to the selected device |
| rd_data | output | 8 | Read byte returned to the processor |

## Verification
The bench builds the block with its default parameters: a 7-bit ROM bank, a 2-bit RAM bank and zero-to-one remapping switched on. These values make the full 21-bit ROM physical range reachable, so bank 0x7F at the top of the window can be checked, as can the 0x80 byte that masks down to bank 0. The 2-bit RAM bank puts bank 3 at the top of the external-RAM window. With the default boot hole limits, both edges of each overlay hole (0x00FF/0x0100, 0x01FF/0x0200, 0x08FF/0x0900) fall inside cartridge ROM space, where the choice between lane 0 and lane 1 is visible.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

   localparam int NDEV = 8;

   localparam int LN_BOOT = 0;
   localparam int LN_ROM  = 1;
   localparam int LN_XRAM = 2;
   localparam int LN_WRAM = 3;
   localparam int LN_DISP = 4;
   localparam int LN_IO   = 5;
   localparam int LN_HRAM = 6;
   localparam int LN_IE   = 7;

   // lanes that accept a store from the processor
   localparam logic [NDEV-1:0] WRITABLE = 8'b1111_1100;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_BOOT,
      RG_ROM_FIXED,
      RG_ROM_WIN,
      RG_DISP,
      RG_XRAM,
      RG_WRAM,
      RG_IO,
      RG_HRAM,
      RG_IE
   } region_e;

   typedef enum logic [1:0] {
      CW_NONE,
      CW_RAM_EN,
      CW_ROM_BANK,
      CW_RAM_BANK
   } ctl_wr_e;

endpackage

// File: rtl/cbm_ctrl_regs.sv
module cbm_ctrl_regs
   import cbm_pkg::*;
#(
   parameter int          ROM_BANK_W = 7,
   parameter int          RAM_BANK_W = 2,
   parameter logic [7:0]  RAM_KEY    = 8'h0A,
   parameter bit          ZERO_REMAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            addr_top,
   input  logic [7:0]            wdata,
   input  logic                  we,
   input  logic                  boot_clr,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  ram_en,
   output logic                  boot_on
);

   ctl_wr_e                 kind;
   logic [ROM_BANK_W-1:0]   rom_masked;
   logic [ROM_BANK_W-1:0]   rom_next;

   always_comb begin
      kind = CW_NONE;
      if (we) begin
         unique case (addr_top)
            3'b000:  kind = CW_RAM_EN;
            3'b001:  kind = CW_ROM_BANK;
            3'b010:  kind = CW_RAM_BANK;
            default: kind = CW_NONE;
         endcase
      end
   end

   generate
      if (ROM_BANK_W >= 8) begin : g_rom_wide
         assign rom_masked = ROM_BANK_W'(wdata);
      end else begin : g_rom_narrow
         assign rom_masked = wdata[ROM_BANK_W-1:0];
      end

      if (ZERO_REMAP) begin : g_remap
         // only an all-zero byte is remapped, not a value that masks to zero
         assign rom_next = (wdata == 8'h00) ? ROM_BANK_W'(1) : rom_masked;
      end else begin : g_direct
         assign rom_next = rom_masked;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_bank <= ROM_BANK_W'(1);
         ram_bank <= '0;
         ram_en   <= 1'b0;
         boot_on  <= 1'b1;
      end else begin
         unique case (kind)
            CW_RAM_EN:   ram_en   <= (wdata == RAM_KEY);
            CW_ROM_BANK: rom_bank <= rom_next;
            CW_RAM_BANK: ram_bank <= wdata[RAM_BANK_W-1:0];
            default: ;
         endcase
         if (boot_clr) boot_on <= 1'b0;
      end
   end

   a_r2_key_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr_top == 3'b000 && wdata == RAM_KEY) |=> ram_en);
   a_r2_other_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr_top == 3'b000 && wdata != RAM_KEY) |=> !ram_en);
   a_r3_zero_gives_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REMAP && we && addr_top == 3'b001 && wdata == 8'h00) |=> rom_bank == ROM_BANK_W'(1));
   a_r4_upper_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr_top == 3'b011) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));
   a_r7_overlay_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_on |=> !boot_on);

endmodule

// File: rtl/cbm_region_decode.sv
module cbm_region_decode
   import cbm_pkg::*;
#(
   parameter int           ROM_BANK_W  = 7,
   parameter int           RAM_BANK_W  = 2,
   parameter logic [15:0]  BOOT_LO_END = 16'h0100,
   parameter logic [15:0]  BOOT_HI_BEG = 16'h0200,
   parameter logic [15:0]  BOOT_HI_END = 16'h0900,
   localparam int          PA_W        = ROM_BANK_W + 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           addr,
   input  logic                  boot_on,
   input  logic                  ram_en,
   input  logic [ROM_BANK_W-1:0] rom_bank,
   input  logic [RAM_BANK_W-1:0] ram_bank,
   output region_e               region,
   output logic [NDEV-1:0]       sel,
   output logic [PA_W-1:0]       paddr,
   output logic                  xram_off
);

   logic in_boot_hole;
   logic in_obj_ram;

   assign in_boot_hole = (addr < BOOT_LO_END) ||
                         ((addr >= BOOT_HI_BEG) && (addr < BOOT_HI_END));
   assign in_obj_ram   = (addr >= 16'hFE00) && (addr < 16'hFEA0);

   always_comb begin
      region = RG_NONE;
      if (boot_on && in_boot_hole)      region = RG_BOOT;
      else if (addr[15:14] == 2'b00)    region = RG_ROM_FIXED;
      else if (addr[15:14] == 2'b01)    region = RG_ROM_WIN;
      else if (addr[15:13] == 3'b100)   region = RG_DISP;
      else if (addr[15:13] == 3'b101)   region = RG_XRAM;
      else if (addr[15:13] == 3'b110)   region = RG_WRAM;
      else if (in_obj_ram)              region = RG_DISP;
      else if (addr[15:7] == 9'h1FE)    region = RG_IO;
      else if (addr == 16'hFFFF)        region = RG_IE;
      else if (addr[15:7] == 9'h1FF)    region = RG_HRAM;
   end

   always_comb begin
      sel      = '0;
      paddr    = '0;
      xram_off = 1'b0;
      unique case (region)
         RG_BOOT: begin
            sel[LN_BOOT] = 1'b1;
            paddr        = PA_W'(addr);
         end
         RG_ROM_FIXED: begin
            sel[LN_ROM] = 1'b1;
            paddr       = PA_W'(addr);
         end
         RG_ROM_WIN: begin
            sel[LN_ROM] = 1'b1;
            paddr       = {rom_bank, addr[13:0]};
         end
         RG_DISP: begin
            sel[LN_DISP] = 1'b1;
            paddr        = PA_W'(addr[14:0]);
         end
         RG_XRAM: begin
            if (ram_en) begin
               sel[LN_XRAM] = 1'b1;
               paddr        = PA_W'({ram_bank, addr[12:0]});
            end else begin
               xram_off = 1'b1;
            end
         end
         RG_WRAM: begin
            sel[LN_WRAM] = 1'b1;
            paddr        = PA_W'(addr[12:0]);
         end
         RG_IO: begin
            sel[LN_IO] = 1'b1;
            paddr      = PA_W'(addr[6:0]);
         end
         RG_HRAM: begin
            sel[LN_HRAM] = 1'b1;
            paddr        = PA_W'(addr[6:0]);
         end
         RG_IE: begin
            sel[LN_IE] = 1'b1;
         end
         default: ;
      endcase
   end

   a_r11_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   a_r7_hole_edge_is_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= BOOT_LO_END && addr < BOOT_HI_BEG) |-> (sel[LN_ROM] && !sel[LN_BOOT]));
   a_r5_window_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[15:14] == 2'b01) |-> (paddr[PA_W-1:14] == rom_bank));

endmodule

// File: rtl/cbm_read_steer.sv
module cbm_read_steer
   import cbm_pkg::*;
#(
   parameter int N = NDEV
) (
   input  logic [N-1:0]   sel,
   input  logic [N*8-1:0] lanes,
   input  logic           xram_off,
   output logic [7:0]     rdata
);

   logic [7:0] gated [N];
   logic [7:0] merged;

   generate
      for (genvar i = 0; i < N; i++) begin : g_lane
         assign gated[i] = lanes[i*8 +: 8] & {8{sel[i]}};
      end
   endgenerate

   always_comb begin
      merged = 8'h00;
      for (int i = 0; i < N; i++) merged = merged | gated[i];
   end

   // a disabled external RAM floats high; an unmapped hole reads zero
   assign rdata = xram_off ? 8'hFF : merged;

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
   import cbm_pkg::*;
#(
   parameter int           ROM_BANK_W  = 7,
   parameter int           RAM_BANK_W  = 2,
   parameter logic [7:0]   RAM_KEY     = 8'h0A,
   parameter bit           ZERO_REMAP  = 1'b1,
   parameter logic [15:0]  BOOT_LO_END = 16'h0100,
   parameter logic [15:0]  BOOT_HI_BEG = 16'h0200,
   parameter logic [15:0]  BOOT_HI_END = 16'h0900,
   localparam int          PA_W        = ROM_BANK_W + 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic              boot_clr,
   input  logic [NDEV*8-1:0] dev_rdata,
   output logic [NDEV-1:0]   dev_sel,
   output logic [PA_W-1:0]   dev_addr,
   output logic              dev_we,
   output logic [7:0]        rd_data
);

   generate
      if (ROM_BANK_W < 1 || ROM_BANK_W > 8) begin : g_bad_rom_w
         $error("ROM_BANK_W must lie in 1..8");
      end
      if (RAM_BANK_W < 1 || RAM_BANK_W > ROM_BANK_W + 1) begin : g_bad_ram_w
         $error("RAM_BANK_W must lie in 1..ROM_BANK_W+1");
      end
      if (BOOT_LO_END > BOOT_HI_BEG || BOOT_HI_BEG > BOOT_HI_END ||
          BOOT_HI_END > 16'h4000) begin : g_bad_boot
         $error("boot holes must be ordered and below 0x4000");
      end
   endgenerate

   logic [ROM_BANK_W-1:0] rom_bank;
   logic [RAM_BANK_W-1:0] ram_bank;
   logic                  ram_en;
   logic                  boot_on;
   region_e               region;
   logic                  xram_off;

   cbm_ctrl_regs #(
      .ROM_BANK_W (ROM_BANK_W),
      .RAM_BANK_W (RAM_BANK_W),
      .RAM_KEY    (RAM_KEY),
      .ZERO_REMAP (ZERO_REMAP)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_top (cpu_addr[15:13]),
      .wdata    (cpu_wdata),
      .we       (cpu_we),
      .boot_clr (boot_clr),
      .rom_bank (rom_bank),
      .ram_bank (ram_bank),
      .ram_en   (ram_en),
      .boot_on  (boot_on)
   );

   cbm_region_decode #(
      .ROM_BANK_W  (ROM_BANK_W),
      .RAM_BANK_W  (RAM_BANK_W),
      .BOOT_LO_END (BOOT_LO_END),
      .BOOT_HI_BEG (BOOT_HI_BEG),
      .BOOT_HI_END (BOOT_HI_END)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (cpu_addr),
      .boot_on  (boot_on),
      .ram_en   (ram_en),
      .rom_bank (rom_bank),
      .ram_bank (ram_bank),
      .region   (region),
      .sel      (dev_sel),
      .paddr    (dev_addr),
      .xram_off (xram_off)
   );

   cbm_read_steer #(
      .N (NDEV)
   ) u_steer (
      .sel      (dev_sel),
      .lanes    (dev_rdata),
      .xram_off (xram_off),
      .rdata    (rd_data)
   );

   assign dev_we = cpu_we && ((dev_sel & WRITABLE) != '0);

   a_r12_rom_space_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15] == 1'b0) |-> !dev_we);
   a_r6_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_XRAM && !ram_en) |-> (!dev_we && rd_data == 8'hFF && dev_sel == '0));
   a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= 16'hE000 && cpu_addr < 16'hFE00) |-> (rd_data == 8'h00 && !dev_we));
   a_r11_lane_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sel[LN_WRAM] |-> (rd_data == dev_rdata[LN_WRAM*8 +: 8]));

endmodule

// File: tb/cart_bank_map_tb.sv
`timescale 1ns/1ps
module cart_bank_map_tb;

   typedef struct packed {
      logic [7:0]  sel;
      logic [20:0] addr;
      logic [7:0]  rd;
      logic        we;
      logic [7:0]  req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic        boot_clr = 1'b0;
   logic [63:0] dev_rdata;
   logic [7:0]  dev_sel;
   logic [20:0] dev_addr;
   logic        dev_we;
   logic [7:0]  rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   exp_t q[$];

   // model state
   logic [6:0] m_rom = 7'd1;
   logic [1:0] m_ram = 2'd0;
   bit         m_en = 1'b0;
   bit         m_boot = 1'b1;

   always #2.5 clk = ~clk;

   initial begin
      for (int i = 0; i < 8; i++) dev_rdata[i*8 +: 8] = 8'(i * 16 + 3);
   end

   cart_bank_map u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_we    (cpu_we),
      .boot_clr  (boot_clr),
      .dev_rdata (dev_rdata),
      .dev_sel   (dev_sel),
      .dev_addr  (dev_addr),
      .dev_we    (dev_we),
      .rd_data   (rd_data)
   );

   function automatic exp_t predict(input logic [15:0] a, input bit w, input logic [7:0] r);
      exp_t e;
      int   ln = -1;
      e.addr = '0; e.rd = 8'h00; e.we = 1'b0; e.req = r;
      if (m_boot && (a < 16'h0100 || (a >= 16'h0200 && a < 16'h0900))) begin
         ln = 0; e.addr = 21'(a);
      end else if (a < 16'h4000) begin
         ln = 1; e.addr = 21'(a);
      end else if (a < 16'h8000) begin
         ln = 1; e.addr = 21'(m_rom) * 21'h4000 + 21'(a - 16'h4000);
      end else if (a < 16'hA000) begin
         ln = 4; e.addr = 21'(a - 16'h8000); e.we = w;
      end else if (a < 16'hC000) begin
         if (m_en) begin
            ln = 2; e.addr = 21'(m_ram) * 21'h2000 + 21'(a - 16'hA000); e.we = w;
         end else e.rd = 8'hFF;
      end else if (a < 16'hE000) begin
         ln = 3; e.addr = 21'(a - 16'hC000); e.we = w;
      end else if (a >= 16'hFE00 && a < 16'hFEA0) begin
         ln = 4; e.addr = 21'(a - 16'h8000); e.we = w;
      end else if (a >= 16'hFF00 && a < 16'hFF80) begin
         ln = 5; e.addr = 21'(a - 16'hFF00); e.we = w;
      end else if (a >= 16'hFF80 && a < 16'hFFFF) begin
         ln = 6; e.addr = 21'(a - 16'hFF80); e.we = w;
      end else if (a == 16'hFFFF) begin
         ln = 7; e.we = w;
      end
      e.sel = (ln >= 0) ? 8'(1 << ln) : 8'h00;
      if (ln >= 0) e.rd = 8'(ln * 16 + 3);
      return e;
   endfunction

   task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit w, input logic [7:0] r);
      @(posedge clk);
      #1;
      cpu_addr = a; cpu_wdata = d; cpu_we = w;
      q.push_back(predict(a, w, r));
      if (w) begin
         if (a < 16'h2000)      m_en = (d == 8'h0A);
         else if (a < 16'h4000) m_rom = (d == 8'h00) ? 7'd1 : d[6:0];
         else if (a < 16'h6000) m_ram = d[1:0];
      end
   endtask

   task automatic clear_boot();
      @(posedge clk);
      #1;
      cpu_we = 1'b0; boot_clr = 1'b1;
      @(posedge clk);
      #1;
      boot_clr = 1'b0; m_boot = 1'b0;
   endtask

   // monitor: compare at the falling edge, mid-cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (dev_sel !== e.sel || dev_addr !== e.addr || rd_data !== e.rd || dev_we !== e.we) begin
            n_fail++;
            $display("FAIL R%0d addr=%h: got sel=%b pa=%h rd=%h we=%b, expected sel=%b pa=%h rd=%h we=%b",
                     e.req, cpu_addr, dev_sel, dev_addr, rd_data, dev_we,
                     e.sel, e.addr, e.rd, e.we);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset bank 1, RAM off, overlay on
      acc(16'h4000, 8'h00, 1'b0, 8'd1);
      acc(16'hA000, 8'h00, 1'b0, 8'd1);
      acc(16'h0000, 8'h00, 1'b0, 8'd1);
      // R7: overlay hole edges
      acc(16'h00FF, 8'h00, 1'b0, 8'd7);
      acc(16'h0100, 8'h00, 1'b0, 8'd7);
      acc(16'h01FF, 8'h00, 1'b0, 8'd7);
      acc(16'h0200, 8'h00, 1'b0, 8'd7);
      acc(16'h08FF, 8'h00, 1'b0, 8'd7);
      acc(16'h0900, 8'h00, 1'b0, 8'd7);
      // R3 and R12: bank select writes, no device strobe
      acc(16'h2100, 8'h05, 1'b1, 8'd12);
      acc(16'h7FFF, 8'h00, 1'b0, 8'd5);   // R5
      acc(16'h2000, 8'h00, 1'b1, 8'd3);
      acc(16'h4001, 8'h00, 1'b0, 8'd3);
      acc(16'h3FFF, 8'h80, 1'b1, 8'd3);
      acc(16'h4000, 8'h00, 1'b0, 8'd3);
      acc(16'h2000, 8'hFF, 1'b1, 8'd3);
      acc(16'h7ABC, 8'h00, 1'b0, 8'd5);
      acc(16'h3ABC, 8'h00, 1'b0, 8'd5);
      // R2 and R4: enable and RAM bank
      acc(16'h0000, 8'h0A, 1'b1, 8'd2);
      acc(16'h4000, 8'h03, 1'b1, 8'd4);
      acc(16'hA123, 8'h00, 1'b0, 8'd6);
      acc(16'hBFFF, 8'h55, 1'b1, 8'd6);
      acc(16'h6000, 8'h00, 1'b1, 8'd4);
      acc(16'hA000, 8'h00, 1'b0, 8'd4);
      acc(16'h1FFF, 8'h0B, 1'b1, 8'd2);
      acc(16'hA000, 8'h00, 1'b0, 8'd6);
      acc(16'hA000, 8'h77, 1'b1, 8'd6);
      // R8: work RAM pages and display
      acc(16'hC000, 8'h11, 1'b1, 8'd8);
      acc(16'hDFFF, 8'h00, 1'b0, 8'd8);
      acc(16'h8000, 8'h00, 1'b0, 8'd8);
      acc(16'h9FFF, 8'h22, 1'b1, 8'd8);
      acc(16'hFE00, 8'h00, 1'b0, 8'd8);
      acc(16'hFE9F, 8'h00, 1'b0, 8'd8);
      // R9: I/O, high RAM, interrupt enable
      acc(16'hFF00, 8'h00, 1'b0, 8'd9);
      acc(16'hFF7F, 8'h33, 1'b1, 8'd9);
      acc(16'hFF80, 8'h00, 1'b0, 8'd9);
      acc(16'hFFFE, 8'h00, 1'b0, 8'd9);
      acc(16'hFFFF, 8'h1F, 1'b1, 8'd9);
      // R10: unmapped holes
      acc(16'hE000, 8'h00, 1'b0, 8'd10);
      acc(16'hF000, 8'h44, 1'b1, 8'd10);
      acc(16'hFEA0, 8'h00, 1'b0, 8'd10);
      acc(16'hFDFF, 8'h00, 1'b1, 8'd10);
      // R11: lane steering with changed read data
      @(posedge clk);
      #1 dev_rdata[3*8 +: 8] = 8'hC5;
      q.push_back('{sel: 8'h08, addr: 21'h0123, rd: 8'hC5, we: 1'b0, req: 8'd11});
      cpu_addr = 16'hC123; cpu_we = 1'b0;
      @(posedge clk);
      #1 dev_rdata[3*8 +: 8] = 8'h33;
      // R7: overlay cleared stays cleared
      clear_boot();
      acc(16'h0000, 8'h00, 1'b0, 8'd7);
      acc(16'h0250, 8'h00, 1'b0, 8'd7);
      acc(16'h08FF, 8'h00, 1'b0, 8'd7);
      @(posedge clk);
      #1 cpu_we = 1'b0;
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule